// File: doc/BRIEF.md
# Group Address Hash Filter

This block makes the receive-side accept/reject call for one destination address at a time. Software programs a 64-bit bitmap, held as two 32-bit halves, plus a 48-bit station address, all through one register write port. For each address offered with a valid strobe, the block finds out whether the address is a group (multicast or broadcast) address or an individual one. A group address is looked up in the bitmap. An individual address is compared with the station address.

The bitmap index is taken straight from the top six bits of the last address octet. No CRC is computed. The all-ones broadcast address therefore always lands on the highest bitmap bit. Because of this, the write port has a "clear" command, which empties the table but keeps that top bit set, and an "accept all" command, which fills the table. A promiscuous input overrides every other rule. The verdict is registered and appears one clock after the strobe.

Top module: `grp_hash_filter`

## Requirements
- R1: After reset both bitmap halves and the station address are zero, and `dec_valid` is low. In this state a group address is rejected and the all-zero individual address is accepted.
- R2: A write with `cfg_wr_sel` = 0 loads bitmap bits 31..0 from `cfg_wr_data`. A write with `cfg_wr_sel` = 1 loads bitmap bits 63..32.
- R3: The address uses this layout: octet k sits at `dst_addr[8k+7:8k]`, the first octet is `dst_addr[7:0]` and the last is `dst_addr[47:40]`. The bitmap index is `dst_addr[47:42]`. An index i below 32 selects bit i of the lower half, and an index of 32 or more selects bit i-32 of the upper half. A group address is accepted exactly when the selected bit is 1.
- R4: The broadcast address 48'hFFFF_FFFF_FFFF uses index 63, so it is accepted exactly when bit 31 of the upper half is set.
- R5: Writing `cfg_wr_sel` = 4 is the clear command. It sets the lower half to 0 and the upper half to 32'h8000_0000, so broadcasts still pass and every other group address is rejected. The data value is ignored.
- R6: Writing `cfg_wr_sel` = 5 is the accept-all command. It sets both halves to 32'hFFFF_FFFF. The data value is ignored.
- R7: An address is a group address when `dst_addr[0]` is 1. Otherwise it is accepted only when it equals the station address, which is written as bits 31..0 through `cfg_wr_sel` = 2 and bits 47..32 through `cfg_wr_data[15:0]` with `cfg_wr_sel` = 3.
- R8: When `promisc` is high during the strobe, the verdict is accept, whatever the bitmap and station address hold.
- R9: `dec_valid` is high in exactly the cycle after each `dst_valid` cycle. Back-to-back strobes give back-to-back verdicts. `dec_accept` is low whenever `dec_valid` is low.
- R10: A lookup in the same cycle as a bitmap write sees the table as it was before that write. The write takes effect for the next lookup.
- R11: Writes with `cfg_wr_sel` = 6 or 7 change nothing. `cfg_wr_data[31:16]` has no effect on a write with `cfg_wr_sel` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register or command select |
| cfg_wr_data | input | 32 | Write data |
| promisc | input | 1 | Accept every address |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first octet in bits 7..0 |
| dec_valid | output | 1 | Verdict valid, one cycle after the strobe |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The hardest case to reach from the ports is a lookup that arrives in the same clock as a write to the bitmap bit it selects. Only that case shows whether the lookup uses the old or the new table contents. The stimulus drives the strobe and the write on one falling edge, then repeats the lookup alone, and expects two different verdicts. Index boundaries come from a vector table built against a sparse bitmap: 0 and 1, 31/32 across the half split, 62 and 63. That table also covers an odd group address whose other octets match the station address.

// File: rtl/grpf_pkg.sv
package grpf_pkg;
  localparam int ADDR_W     = 48;
  localparam int OCT_W      = 8;
  localparam int REG_W      = 32;
  localparam int HASH_BITS  = 64;
  localparam int NUM_HALVES = HASH_BITS / REG_W;
  localparam int IDX_W      = $clog2(HASH_BITS);
  localparam int SEL_W      = 3;
  localparam int OWN_HI_W   = ADDR_W - REG_W;

  localparam logic [SEL_W-1:0] SEL_OWN_LO = SEL_W'(NUM_HALVES);
  localparam logic [SEL_W-1:0] SEL_OWN_HI = SEL_W'(NUM_HALVES + 1);
  localparam logic [SEL_W-1:0] SEL_CLEAR  = SEL_W'(NUM_HALVES + 2);
  localparam logic [SEL_W-1:0] SEL_ALL    = SEL_W'(NUM_HALVES + 3);

  localparam logic [HASH_BITS-1:0] CLEAR_PAT = {1'b1, {(HASH_BITS-1){1'b0}}};

  typedef struct packed {
    logic valid;
    logic accept;
  } verdict_t;
endpackage

// File: rtl/grpf_cfg_regs.sv
module grpf_cfg_regs
  import grpf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  output logic [HASH_BITS-1:0] hash_tbl,
  output logic [ADDR_W-1:0]    own_addr
);
  logic [REG_W-1:0]    own_lo;
  logic [OWN_HI_W-1:0] own_hi;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [REG_W-1:0] half_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        half_q <= '0;
      end else if (wr_en) begin
        if (wr_sel == SEL_W'(h))
          half_q <= wr_data;
        else if (wr_sel == SEL_CLEAR)
          half_q <= CLEAR_PAT[h*REG_W +: REG_W];
        else if (wr_sel == SEL_ALL)
          half_q <= '1;
      end
    end
    assign hash_tbl[h*REG_W +: REG_W] = half_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_lo <= '0;
      own_hi <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_OWN_LO) own_lo <= wr_data;
      if (wr_sel == SEL_OWN_HI) own_hi <= wr_data[OWN_HI_W-1:0];
    end
  end

  assign own_addr = {own_hi, own_lo};
endmodule

// File: rtl/grpf_lookup.sv
module grpf_lookup
  import grpf_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 promisc,
  input  logic [HASH_BITS-1:0] hash_tbl,
  input  logic [ADDR_W-1:0]    own_addr,
  output logic                 accept
);
  logic [IDX_W-1:0] idx;
  logic             is_group;
  logic             hash_hit;
  logic             own_hit;

  // index: upper bits of the last octet
  assign idx      = addr[ADDR_W-1 -: IDX_W];
  assign is_group = addr[0];
  assign hash_hit = hash_tbl[idx];
  assign own_hit  = (addr == own_addr);

  always_comb begin
    if (promisc)       accept = 1'b1;
    else if (is_group) accept = hash_hit;
    else               accept = own_hit;
  end
endmodule

// File: rtl/grpf_decide.sv
module grpf_decide
  import grpf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  logic     in_accept,
  output verdict_t verdict
);
  always_ff @(posedge clk) begin
    if (rst) begin
      verdict <= '0;
    end else begin
      verdict.valid  <= in_valid;
      verdict.accept <= in_valid & in_accept;
    end
  end
endmodule

// File: rtl/grp_hash_filter.sv
module grp_hash_filter
  import grpf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en,
  input  logic [SEL_W-1:0]   cfg_wr_sel,
  input  logic [REG_W-1:0]   cfg_wr_data,
  input  logic               promisc,
  input  logic               dst_valid,
  input  logic [ADDR_W-1:0]  dst_addr,
  output logic               dec_valid,
  output logic               dec_accept
);
  logic [HASH_BITS-1:0] hash_tbl;
  logic [ADDR_W-1:0]    own_addr;
  logic                 raw_accept;
  verdict_t             verdict;

  grpf_cfg_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .wr_sel   (cfg_wr_sel),
    .wr_data  (cfg_wr_data),
    .hash_tbl (hash_tbl),
    .own_addr (own_addr)
  );

  grpf_lookup u_lookup (
    .addr     (dst_addr),
    .promisc  (promisc),
    .hash_tbl (hash_tbl),
    .own_addr (own_addr),
    .accept   (raw_accept)
  );

  grpf_decide u_decide (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (dst_valid),
    .in_accept (raw_accept),
    .verdict   (verdict)
  );

  assign dec_valid  = verdict.valid;
  assign dec_accept = verdict.accept;
endmodule

// File: rtl/grpf_checker.sv
module grpf_checker
  import grpf_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_wr_en,
  input logic [SEL_W-1:0]     cfg_wr_sel,
  input logic                 promisc,
  input logic                 dst_valid,
  input logic                 dec_valid,
  input logic                 dec_accept,
  input logic [HASH_BITS-1:0] hash_tbl
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    dst_valid |=> dec_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !dst_valid |=> !dec_valid);
  a_r9_accept_gated: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_accept);
  a_r8_promisc: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && promisc) |=> dec_accept);
  a_r5_clear_pattern: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_wr_sel == SEL_CLEAR) |=> (hash_tbl == CLEAR_PAT));
  a_r6_fill: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_wr_sel == SEL_ALL) |=> (&hash_tbl));
  a_r11_idle_sel: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_wr_sel > SEL_ALL) |=> $stable(hash_tbl));
endmodule

bind grp_hash_filter grpf_checker u_grpf_checker (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wr_sel (cfg_wr_sel),
  .promisc    (promisc),
  .dst_valid  (dst_valid),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .hash_tbl   (hash_tbl)
);

// File: tb/test_grp_hash_filter.sv
`timescale 1ns/1ps
module test_grp_hash_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        promisc = 1'b0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        dec_valid;
  logic        dec_accept;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  grp_hash_filter i_grp_hash_filter (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .promisc(promisc), .dst_valid(dst_valid),
    .dst_addr(dst_addr), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // {addr, promisc, expected accept}; table lo=0x5, hi=0x8000_0002,
  // station address 48'h1234_5678_9ABC
  localparam logic [49:0] VEC [14] = '{
    {48'h00_00_00_00_00_01, 1'b0, 1'b1},  // R3 idx0
    {48'h03_00_00_00_00_01, 1'b0, 1'b1},  // R3 idx0, low bits ignored
    {48'h04_00_00_00_00_01, 1'b0, 1'b0},  // R3 idx1
    {48'h08_00_00_00_00_01, 1'b0, 1'b1},  // R3 idx2
    {48'h7C_00_00_00_00_01, 1'b0, 1'b0},  // R3 idx31
    {48'h84_00_00_00_00_01, 1'b0, 1'b1},  // R3 idx33
    {48'h80_00_00_00_00_01, 1'b0, 1'b0},  // R3 idx32
    {48'hFF_FF_FF_FF_FF_FF, 1'b0, 1'b1},  // R4 broadcast
    {48'hFC_00_00_00_00_01, 1'b0, 1'b1},  // R4 idx63
    {48'hF8_00_00_00_00_01, 1'b0, 1'b0},  // R3 idx62
    {48'h12_34_56_78_9A_BC, 1'b0, 1'b1},  // R7 own match
    {48'h12_34_56_78_9A_BE, 1'b0, 1'b0},  // R7 mismatch
    {48'h12_34_56_78_9A_BD, 1'b0, 1'b0},  // R7 group, idx4 clear
    {48'h00_00_00_00_00_02, 1'b1, 1'b1}   // R8 promisc
  };

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic look(input logic [47:0] a, input logic p, input logic exp,
                      input string req);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a; promisc = p;
    @(negedge clk);
    dst_valid = 1'b0; promisc = 1'b0;
    check(dec_valid, 1'b1, req);
    check(dec_accept, exp, req);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(dec_valid, 1'b0, "R1");
    look(48'hFF_FF_FF_FF_FF_FF, 1'b0, 1'b0, "R1");
    look(48'h0, 1'b0, 1'b1, "R1");

    // R2/R7 programming, then vector walk
    wr(3'd0, 32'h0000_0005);
    wr(3'd1, 32'h8000_0002);
    wr(3'd2, 32'h5678_9ABC);
    wr(3'd3, 32'hABCD_1234);   // R11 upper data bits dropped
    foreach (VEC[i]) look(VEC[i][49:2], VEC[i][1], VEC[i][0], "R3/R4/R7/R8/R2");

    // R9 back-to-back strobes, then idle
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = 48'h08_00_00_00_00_01;
    @(negedge clk);
    dst_addr = 48'h04_00_00_00_00_01;
    check(dec_valid, 1'b1, "R9"); check(dec_accept, 1'b1, "R9");
    @(negedge clk);
    dst_valid = 1'b0;
    check(dec_valid, 1'b1, "R9"); check(dec_accept, 1'b0, "R9");
    @(negedge clk);
    check(dec_valid, 1'b0, "R9"); check(dec_accept, 1'b0, "R9");

    // R5 clear
    wr(3'd4, 32'h1234_5678);
    look(48'hFF_FF_FF_FF_FF_FF, 1'b0, 1'b1, "R5");
    look(48'h00_00_00_00_00_01, 1'b0, 1'b0, "R5");
    look(48'h84_00_00_00_00_01, 1'b0, 1'b0, "R5");

    // R6 accept all
    wr(3'd5, 32'h0);
    look(48'h04_00_00_00_00_01, 1'b0, 1'b1, "R6");
    look(48'h80_00_00_00_00_01, 1'b0, 1'b1, "R6");

    // R10 write and lookup in the same cycle
    wr(3'd4, 32'h0);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 3'd0; cfg_wr_data = 32'h0000_0002;
    dst_valid = 1'b1; dst_addr = 48'h04_00_00_00_00_01;
    @(negedge clk);
    cfg_wr_en = 1'b0; dst_valid = 1'b0;
    check(dec_accept, 1'b0, "R10");
    look(48'h04_00_00_00_00_01, 1'b0, 1'b1, "R10");

    // R11 idle selects have no effect
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    look(48'h00_00_00_00_00_01, 1'b0, 1'b0, "R11");
    look(48'hF8_00_00_00_00_01, 1'b0, 1'b0, "R11");
    look(48'h12_34_56_78_9A_BC, 1'b0, 1'b1, "R11");

    // R7 new station address, upper data bits set
    wr(3'd2, 32'h0);
    wr(3'd3, 32'hFFFF_0002);
    look(48'h00_02_00_00_00_00, 1'b0, 1'b1, "R7");
    look(48'hFF_FF_00_00_00_00, 1'b0, 1'b0, "R11");

    finish_run();
  end
endmodule